// File: doc/BRIEF.md
# Card Command Issue Unit

This unit sits between a register bank and the serializer that drives a memory card's command line. Software loads a 32-bit argument, then writes a command word that holds the command index, a set of control flags and a start bit. The unit decodes the flags and, when allowed, presents one command frame request to the serializer. If a response is expected, it waits for one, stores the response bits in four response words and reports the outcome in a small set of raw status bits. Software clears these bits by writing ones to them.

A command can be told to wait until the data line is no longer busy. An abort/stop command goes out even while data is still moving. Responses are either short or long. A long response spreads 128 bits over all four response words. A timer counts card clock ticks while the unit waits for a response. When the programmed limit is reached, the command ends with a timeout.

Top module: `cmd_issue_unit`

## Requirements
- R1: Command word layout: bits [5:0] index, bit 6 response-expected, bit 7 long response, bit 8 check CRC, bit 9 data-expected, bit 10 write direction, bit 11 stop/abort, bit 12 wait-for-previous-data, bit 31 start. While `frame_valid` is high, the frame outputs carry the latched index, argument and flags, and they hold steady until `frame_ready` is seen.
- R2: When wait-for-previous-data is set and abort is clear, `frame_valid` stays low for as long as `data_busy` is high. It rises only after `data_busy` goes low.
- R3: An abort command does not wait for `data_busy`, even when wait-for-previous-data is also set.
- R4: `cmd_rdata[31]` reads 1 from the write that sets start until the serializer accepts the frame, and 0 afterwards. Command and argument writes made while start reads 1 are ignored.
- R5: A short response writes `rsp_bits[31:0]` into `resp0` and leaves `resp1` to `resp3` unchanged.
- R6: A long response writes `resp3`=`rsp_bits[127:96]`, `resp2`=`rsp_bits[95:64]`, `resp1`=`rsp_bits[63:32]` and `resp0`=`rsp_bits[31:0]`.
- R7: Raw status bit 0 (command done) is set when a response arrives. For a command with no response expected, it is set when the frame is accepted.
- R8: If no response arrives within `tmo_limit` card ticks, raw status bit 1 (timeout) and bit 0 are set together.
- R9: A response flagged with `rsp_err` sets raw status bit 2 (response error).
- R10: A failed CRC (`rsp_crc_ok` low) sets raw status bit 3 only if check CRC was requested.
- R11: Writing a one to a raw status bit through `sts_clr_mask` clears that bit. Bits written with zero keep their value.
- R12: After reset, raw status, the start bit, `frame_valid` and the response words are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| arg_wr | input | 1 | Argument register write |
| arg_wdata | input | 32 | Argument value |
| cmd_wr | input | 1 | Command register write |
| cmd_wdata | input | 32 | Command word |
| sts_clr_wr | input | 1 | Raw status clear strobe |
| sts_clr_mask | input | 4 | Ones clear the matching status bits |
| tmo_limit | input | TMO_W | Response timeout in card ticks |
| card_tick | input | 1 | One pulse per card clock |
| data_busy | input | 1 | Data line busy |
| cmd_rdata | output | 32 | Command register readback, bit 31 start |
| resp0 | output | 32 | Response word 0 |
| resp1 | output | 32 | Response word 1 |
| resp2 | output | 32 | Response word 2 |
| resp3 | output | 32 | Response word 3 |
| raw_status | output | 4 | {crc_err, rsp_err, timeout, done} |
| frame_valid | output | 1 | Frame request to serializer |
| frame_ready | input | 1 | Serializer takes the frame |
| frame_index | output | 6 | Command index |
| frame_arg | output | 32 | Command argument |
| frame_resp_exp | output | 1 | Response expected |
| frame_long | output | 1 | Long response |
| frame_data_exp | output | 1 | Data phase follows |
| frame_write | output | 1 | Data direction is write |
| frame_abort | output | 1 | Stop/abort command |
| rsp_valid | input | 1 | Response present this cycle |
| rsp_bits | input | 128 | Response payload |
| rsp_err | input | 1 | Response framing/index error |
| rsp_crc_ok | input | 1 | Response CRC matched |

## Verification
The assertions assume that the serializer never raises `frame_ready` without a pending request. They also assume that `rsp_valid` pulses for one cycle and only after a frame has been accepted. The stimulus meets both conditions: a single serving task raises `frame_ready` only after it has seen `frame_valid`, and it pulses the response only after that acceptance. The bench changes `data_busy` only between commands or while the unit is holding a command back, and it keeps `tmo_limit` constant for the length of each command.

// File: rtl/cmd_issue_unit.sv
module cmd_issue_unit #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arg_wr,
  input  logic [31:0]      arg_wdata,
  input  logic             cmd_wr,
  input  logic [31:0]      cmd_wdata,
  input  logic             sts_clr_wr,
  input  logic [3:0]       sts_clr_mask,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             card_tick,
  input  logic             data_busy,
  output logic [31:0]      cmd_rdata,
  output logic [31:0]      resp0,
  output logic [31:0]      resp1,
  output logic [31:0]      resp2,
  output logic [31:0]      resp3,
  output logic [3:0]       raw_status,
  output logic             frame_valid,
  input  logic             frame_ready,
  output logic [5:0]       frame_index,
  output logic [31:0]      frame_arg,
  output logic             frame_resp_exp,
  output logic             frame_long,
  output logic             frame_data_exp,
  output logic             frame_write,
  output logic             frame_abort,
  input  logic             rsp_valid,
  input  logic [127:0]     rsp_bits,
  input  logic             rsp_err,
  input  logic             rsp_crc_ok
);

  localparam int B_RESP  = 6;
  localparam int B_LONG  = 7;
  localparam int B_CRC   = 8;
  localparam int B_DATA  = 9;
  localparam int B_WRITE = 10;
  localparam int B_ABORT = 11;
  localparam int B_WAIT  = 12;
  localparam int B_START = 31;

  localparam int S_DONE = 0;
  localparam int S_TMO  = 1;
  localparam int S_RERR = 2;
  localparam int S_CRC  = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_ISSUE, ST_WAIT} state_t;

  state_t           state;
  logic [30:0]      cmd_q;
  logic             start_q;
  logic [31:0]      arg_q;
  logic [TMO_W-1:0] tmo_cnt;
  logic [3:0]       sts_set;
  logic             accept;
  logic             tmo_hit;
  logic             hold_off;

  assign cmd_rdata      = {start_q, cmd_q};
  assign frame_valid    = (state == ST_ISSUE);
  assign frame_index    = cmd_q[5:0];
  assign frame_arg      = arg_q;
  assign frame_resp_exp = cmd_q[B_RESP];
  assign frame_long     = cmd_q[B_LONG];
  assign frame_data_exp = cmd_q[B_DATA];
  assign frame_write    = cmd_q[B_WRITE];
  assign frame_abort    = cmd_q[B_ABORT];

  assign accept   = frame_valid && frame_ready;
  assign hold_off = cmd_q[B_WAIT] && !cmd_q[B_ABORT] && data_busy;
  assign tmo_hit  = (state == ST_WAIT) && !rsp_valid && card_tick &&
                    (({1'b0, tmo_cnt} + 1'b1) >= {1'b0, tmo_limit});

  always_comb begin
    sts_set = '0;
    if (accept && !cmd_q[B_RESP]) sts_set[S_DONE] = 1'b1;
    if (state == ST_WAIT && rsp_valid) begin
      sts_set[S_DONE] = 1'b1;
      sts_set[S_RERR] = rsp_err;
      sts_set[S_CRC]  = cmd_q[B_CRC] && !rsp_crc_ok;
    end
    if (tmo_hit) begin
      sts_set[S_DONE] = 1'b1;
      sts_set[S_TMO]  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cmd_q   <= '0;
      start_q <= 1'b0;
      arg_q   <= '0;
      tmo_cnt <= '0;
    end else begin
      if (!start_q && state == ST_IDLE) begin
        if (arg_wr) arg_q <= arg_wdata;
        if (cmd_wr) begin
          cmd_q   <= cmd_wdata[30:0];
          start_q <= cmd_wdata[B_START];
          if (cmd_wdata[B_START]) state <= ST_HOLD;
        end
      end
      case (state)
        ST_HOLD:  if (!hold_off) state <= ST_ISSUE;
        ST_ISSUE: if (frame_ready) begin
                    start_q <= 1'b0;
                    tmo_cnt <= '0;
                    state   <= cmd_q[B_RESP] ? ST_WAIT : ST_IDLE;
                  end
        ST_WAIT:  if (rsp_valid || tmo_hit) state <= ST_IDLE;
                  else if (card_tick) tmo_cnt <= tmo_cnt + 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp0 <= '0;
      resp1 <= '0;
      resp2 <= '0;
      resp3 <= '0;
    end else if (state == ST_WAIT && rsp_valid) begin
      resp0 <= rsp_bits[31:0];
      if (cmd_q[B_LONG]) begin
        resp1 <= rsp_bits[63:32];
        resp2 <= rsp_bits[95:64];
        resp3 <= rsp_bits[127:96];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_status <= '0;
    else raw_status <= (raw_status & ~(sts_clr_wr ? sts_clr_mask : 4'b0)) | sts_set;
  end

  a_r1_frame_steady: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid && !frame_ready |=> frame_valid && $stable(frame_index) && $stable(frame_arg));

  a_r2_no_issue_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_valid) && cmd_q[B_WAIT] && !cmd_q[B_ABORT] |-> !$past(data_busy));

  a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid && frame_ready |=> !cmd_rdata[B_START]);

  a_r8_tmo_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_status[S_TMO]) |-> raw_status[S_DONE]);

  a_r10_crc_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_status[S_CRC]) |-> cmd_q[B_CRC]);

endmodule

// File: tb/cmd_issue_unit_bench.sv
module cmd_issue_unit_bench;
  logic clk = 0, rst_n = 0;
  logic arg_wr = 0, cmd_wr = 0, sts_clr_wr = 0;
  logic [31:0] arg_wdata = 0, cmd_wdata = 0;
  logic [3:0] sts_clr_mask = 0;
  logic [15:0] tmo_limit = 16'd5;
  logic card_tick = 0, data_busy = 0;
  logic [31:0] cmd_rdata, resp0, resp1, resp2, resp3;
  logic [3:0] raw_status;
  logic frame_valid, frame_ready = 0;
  logic [5:0] frame_index;
  logic [31:0] frame_arg;
  logic frame_resp_exp, frame_long, frame_data_exp, frame_write, frame_abort;
  logic rsp_valid = 0, rsp_err = 0, rsp_crc_ok = 1;
  logic [127:0] rsp_bits = 0;

  int checks = 0, fails = 0;
  logic [5:0] seen_idx;
  logic [31:0] seen_arg;
  logic [4:0] seen_flags;
  bit seen_frame;

  always #2 clk = ~clk;

  cmd_issue_unit #(.TMO_W(16)) u_cmd_issue_unit (.*);

  initial forever begin
    @(negedge clk); card_tick = 1;
    @(negedge clk); card_tick = 0;
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(input logic [5:0] idx, input bit resp, input bit lng,
      input bit crc, input bit abrt, input bit wt);
    cw = 32'h8000_0000 | {19'b0, wt, abrt, 2'b00, crc, lng, resp, idx};
  endfunction

  task automatic issue(input logic [31:0] cmd, input logic [31:0] arg);
    @(negedge clk);
    arg_wr = 1; arg_wdata = arg; cmd_wr = 1; cmd_wdata = cmd;
    @(negedge clk);
    arg_wr = 0; cmd_wr = 0;
  endtask

  task automatic clear_all();
    @(negedge clk); sts_clr_wr = 1; sts_clr_mask = 4'hF;
    @(negedge clk); sts_clr_wr = 0; sts_clr_mask = 0;
  endtask

  task automatic serve(input bit resp, input int dly, input logic [127:0] bits,
      input bit err, input bit crcok);
    int n;
    seen_frame = 0;
    n = 0;
    while (!frame_valid && n < 50) begin @(negedge clk); n++; end
    if (frame_valid) begin
      seen_frame = 1;
      seen_idx = frame_index; seen_arg = frame_arg;
      seen_flags = {frame_resp_exp, frame_long, frame_data_exp, frame_write, frame_abort};
      frame_ready = 1;
      @(negedge clk);
      frame_ready = 0;
      if (resp) begin
        repeat (dly) @(negedge clk);
        rsp_valid = 1; rsp_bits = bits; rsp_err = err; rsp_crc_ok = crcok;
        @(negedge clk);
        rsp_valid = 0; rsp_err = 0; rsp_crc_ok = 1;
      end
    end
  endtask

  task automatic t_reset();
    chk(raw_status == 0, "R12 status", raw_status, 0);
    chk(cmd_rdata[31] == 0, "R12 start", cmd_rdata[31], 0);
    chk(frame_valid == 0, "R12 frame_valid", frame_valid, 0);
    chk({resp3, resp2, resp1, resp0} == 0, "R12 resp", {resp3, resp2, resp1, resp0}, 0);
  endtask

  task automatic t_short();
    clear_all();
    issue(cw(6'd17, 1, 0, 1, 0, 0) | 32'h0000_0600, 32'hCAFE_0001);
    serve(1, 3, 128'hAAAA_0000_BBBB_1111_CCCC_2222_1234_5678, 0, 1);
    @(negedge clk);
    chk(seen_frame && seen_idx == 17, "R1 index", seen_idx, 17);
    chk(seen_arg == 32'hCAFE_0001, "R1 arg", seen_arg, 32'hCAFE_0001);
    chk(seen_flags == 5'b10110, "R1 flags", seen_flags, 5'b10110);
    chk(resp0 == 32'h1234_5678, "R5 resp0", resp0, 32'h1234_5678);
    chk(resp1 == 0 && resp2 == 0 && resp3 == 0, "R5 upper untouched", {resp3, resp2, resp1}, 0);
    chk(raw_status == 4'b0001, "R7 done only", raw_status, 4'b0001);
    chk(cmd_rdata[31] == 0, "R4 start cleared", cmd_rdata[31], 0);
  endtask

  task automatic t_long();
    clear_all();
    issue(cw(6'd2, 1, 1, 0, 0, 0), 32'h0);
    serve(1, 2, 128'h4444_4444_3333_3333_2222_2222_1111_1111, 0, 1);
    @(negedge clk);
    chk(resp3 == 32'h4444_4444, "R6 resp3", resp3, 32'h4444_4444);
    chk(resp2 == 32'h3333_3333, "R6 resp2", resp2, 32'h3333_3333);
    chk(resp1 == 32'h2222_2222, "R6 resp1", resp1, 32'h2222_2222);
    chk(resp0 == 32'h1111_1111, "R6 resp0", resp0, 32'h1111_1111);
    chk(raw_status == 4'b0001, "R7 long done", raw_status, 4'b0001);
  endtask

  task automatic t_noresp();
    clear_all();
    issue(cw(6'd0, 0, 0, 0, 0, 0), 32'h0);
    serve(0, 0, 0, 0, 1);
    chk(raw_status == 4'b0001, "R7 no-response done", raw_status, 4'b0001);
    chk(resp0 == 32'h1111_1111, "R7 resp0 kept", resp0, 32'h1111_1111);
  endtask

  task automatic t_busy_wait();
    clear_all();
    data_busy = 1;
    issue(cw(6'd24, 0, 0, 0, 0, 1), 32'h55);
    repeat (6) @(negedge clk);
    chk(frame_valid == 0, "R2 held while busy", frame_valid, 0);
    chk(cmd_rdata[31] == 1, "R4 start reads 1", cmd_rdata[31], 1);
    issue(cw(6'd9, 0, 0, 0, 0, 0), 32'h99);
    data_busy = 0;
    serve(0, 0, 0, 0, 1);
    chk(seen_frame, "R2 issued after busy", seen_frame, 1);
    chk(seen_idx == 24 && seen_arg == 32'h55, "R4 write ignored while pending",
        {seen_idx, seen_arg}, {6'd24, 32'h55});
  endtask

  task automatic t_abort();
    clear_all();
    data_busy = 1;
    issue(cw(6'd12, 1, 0, 0, 1, 1), 32'h0);
    serve(1, 1, 128'h77, 0, 1);
    data_busy = 0;
    @(negedge clk);
    chk(seen_frame && seen_flags[0], "R3 abort goes while busy", seen_frame, 1);
    chk(raw_status == 4'b0001, "R3 abort done", raw_status, 4'b0001);
  endtask

  task automatic t_timeout();
    int n;
    clear_all();
    tmo_limit = 16'd5;
    issue(cw(6'd8, 1, 0, 1, 0, 0), 32'h1AA);
    serve(0, 0, 0, 0, 1);
    @(negedge clk);
    chk(raw_status == 0, "R8 not early", raw_status, 0);
    n = 0;
    while (raw_status == 0 && n < 40) begin @(negedge clk); n++; end
    chk(raw_status == 4'b0011, "R8 timeout+done", raw_status, 4'b0011);
    chk(n >= 4 && n <= 14, "R8 timeout window", n, 9);
    @(negedge clk); sts_clr_wr = 1; sts_clr_mask = 4'b0010;
    @(negedge clk); sts_clr_wr = 0; sts_clr_mask = 0;
    chk(raw_status == 4'b0001, "R11 w1c single bit", raw_status, 4'b0001);
    clear_all();
    chk(raw_status == 0, "R11 w1c all", raw_status, 0);
  endtask

  task automatic t_rsp_err();
    clear_all();
    issue(cw(6'd3, 1, 0, 0, 0, 0), 32'h0);
    serve(1, 2, 128'h5, 1, 1);
    @(negedge clk);
    chk(raw_status == 4'b0101, "R9 response error", raw_status, 4'b0101);
  endtask

  task automatic t_crc();
    clear_all();
    issue(cw(6'd7, 1, 0, 1, 0, 0), 32'h0);
    serve(1, 2, 128'h6, 0, 0);
    @(negedge clk);
    chk(raw_status == 4'b1001, "R10 crc checked", raw_status, 4'b1001);
    clear_all();
    issue(cw(6'd7, 1, 0, 0, 0, 0), 32'h0);
    serve(1, 2, 128'h6, 0, 0);
    @(negedge clk);
    chk(raw_status == 4'b0001, "R10 crc unchecked", raw_status, 4'b0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_short();
    t_long();
    t_noresp();
    t_busy_wait();
    t_abort();
    t_timeout();
    t_rsp_err();
    t_crc();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule